// File: doc/BRIEF.md
# Parallel Port Edge Interrupt Controller

This block is a 16-line general-purpose parallel port. Each line can be an input or an output. An input line is resynchronized to the system clock and watched for transitions. Each line has its own choice of trigger: any transition, or a high-to-low transition only. A qualifying transition sets a sticky bit in an event register. Software clears that bit by writing a one to it. The masked OR of all event bits drives one registered interrupt output.

The two highest lines can also drive DMA request outputs. Each of these requests is either a one-cycle pulse on a falling edge or a level that follows the inverted pin. Each line selects its own behaviour. The DMA path runs alongside the interrupt path and does not change it.

The block has two synchronous, active-high resets. The hard reset clears everything. The soft reset clears everything except the trigger-mode register.

A small register port gives access to the control and status registers: address, write enable, write data and registered read data.

Top module: `pio_edge_irq`

## Requirements
- R1: After either reset, these all read zero: direction, output data, event, mask and DMA-control registers. The `irq` and `dma_req` outputs are low. After a hard reset the trigger-mode register also reads zero.
- R2: Bits 3..0 of the trigger-mode register (address 3) always read zero, whatever is written to them. Bits 15..4 read back as written.
- R3: Trigger-mode bit 0 means any transition, so both a rising and a falling change on an input line set its event bit. The event bit becomes readable on the third rising clock edge after the pin changes.
- R4: Trigger-mode bit 1 means falling edge only. A rising change on that line sets no event bit, and a falling change does.
- R5: A line with its direction bit at 1 (an output) never sets its event bit, whatever its pin does.
- R6: The event register (address 4) is write-one-to-clear. Writing a 0 bit leaves that bit unchanged. If a clear and a new event on the same bit meet in one cycle, the bit stays set.
- R7: `irq` is the OR over all lines of (event AND mask), with the mask at address 5. It is registered, so it rises one cycle after the event bit is set. A masked-off event leaves it low, and clearing the event drops it.
- R8: The soft reset keeps the trigger-mode register and clears the other registers. A hard reset clears the trigger-mode register too.
- R9: For the DMA lines (pins 14 and 15), the DMA-control register at address 6 holds the enables in bits 1:0 (bit 0 for pin 14) and the level-select bits in bits 3:2. When a line is enabled with level-select 0, its `dma_req` bit pulses high for exactly one cycle per falling edge. This happens on the same edge that sets the event bit. Rising edges give no pulse, and the event bit still follows the trigger mode.
- R10: When a DMA line is enabled with level-select 1, its `dma_req` bit equals the inverted synchronized pin level. That level is registered, so it appears on the third clock edge after the pin changes. A line that is not enabled keeps its `dma_req` bit low.
- R11: The register map is: 0 direction (1 = output, drives `pin_oe`), 1 output data (drives `pin_o`), 2 synchronized pin levels (read only), 3 trigger mode, 4 event, 5 mask, 6 DMA control. `rdata` is updated on the clock edge after `addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hrst | input | 1 | Hard reset, synchronous, active high |
| srst | input | 1 | Soft reset, synchronous, active high; keeps the trigger mode |
| addr | input | 3 | Register address |
| we | input | 1 | Write enable |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| pin_i | input | 16 | Asynchronous pin inputs |
| pin_o | output | 16 | Output data to pins |
| pin_oe | output | 16 | Per-line output enable |
| irq | output | 1 | Combined interrupt request |
| dma_req | output | 2 | DMA requests for pins 14 and 15 |

## Verification
Suppose a pin changes just before clock edge k. The pin passes through two synchronizer flops, so detection fires during the cycle after edge k+1. The event bit and any edge-sensitive or level-sensitive DMA request register on edge k+2, and `irq` follows on edge k+3. A register read captures on the edge after its address is presented.

The bench drives every stimulus on a falling clock edge. It counts falling edges from the change to the sample point, and it checks both the cycle just before each result is due and the cycle it appears. Register reads go into a queue of expected values, and a monitor compares each one just after the edge that loads `rdata`. The bench lines up a write-one-to-clear to land on exactly edge k+2 of a new event, which exercises the case where both happen in the same cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [2:0] {
    A_DIR  = 3'd0,
    A_OUT  = 3'd1,
    A_PIN  = 3'd2,
    A_EDGE = 3'd3,
    A_EVT  = 3'd4,
    A_MASK = 3'd5,
    A_DMA  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int NLINES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] pin_i,
  input  logic [NLINES-1:0] edge_mode,
  output logic [NLINES-1:0] lvl,
  output logic [NLINES-1:0] fall,
  output logic [NLINES-1:0] det
);
  logic [NLINES-1:0] s1, s2, prv;
  logic [1:0]        arm_cnt;
  logic              armed;

  // two-flop synchronizer plus one history stage
  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= '0;
      s2      <= '0;
      prv     <= '0;
      arm_cnt <= '0;
    end else begin
      s1  <= pin_i;
      s2  <= s1;
      prv <= s2;
      if (arm_cnt != 2'd3) arm_cnt <= arm_cnt + 2'd1;
    end
  end

  // history is only meaningful once three stages have loaded
  assign armed = (arm_cnt == 2'd3);
  assign lvl   = s2;
  assign fall  = {NLINES{armed}} & prv & ~s2;

  for (genvar i = 0; i < NLINES; i++) begin : g_det
    assign det[i] = armed & (edge_mode[i] ? (prv[i] & ~s2[i]) : (prv[i] ^ s2[i]));

    // R4
    falling_only_chk: assert property (@(posedge clk) disable iff (rst)
      (edge_mode[i] && det[i]) |-> !s2[i]);
  end
endmodule

// File: rtl/pio_evt.sv
module pio_evt #(
  parameter int NLINES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] det,
  input  logic [NLINES-1:0] dir,
  input  logic [NLINES-1:0] clr,
  input  logic [NLINES-1:0] mask,
  output logic [NLINES-1:0] ev,
  output logic              irq
);
  logic [NLINES-1:0] hit;

  assign hit = det & ~dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev  <= '0;
      irq <= 1'b0;
    end else begin
      ev  <= (ev & ~clr) | hit;
      irq <= |(ev & mask);
    end
  end

  // R6
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((ev & $past(hit)) == $past(hit)));

  // R5
  out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ev & ~$past(ev) & $past(dir)) == '0));

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ((ev & mask) == '0) |=> !irq);
endmodule

// File: rtl/pio_dma.sv
module pio_dma #(
  parameter int DMA_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DMA_N-1:0] en,
  input  logic [DMA_N-1:0] lvl_mode,
  input  logic [DMA_N-1:0] pin_lvl,
  input  logic [DMA_N-1:0] pin_fall,
  output logic [DMA_N-1:0] req
);
  for (genvar j = 0; j < DMA_N; j++) begin : g_req
    always_ff @(posedge clk) begin
      if (rst) req[j] <= 1'b0;
      else     req[j] <= en[j] & (lvl_mode[j] ? ~pin_lvl[j] : pin_fall[j]);
    end

    // R9
    dma_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      ($stable(lvl_mode[j]) && !lvl_mode[j] && req[j]) |=> !req[j]);

    // R10
    dma_level_chk: assert property (@(posedge clk) disable iff (rst)
      (en[j] && lvl_mode[j] && !pin_lvl[j]) |=> req[j]);
  end
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int NLINES  = 16,
  parameter int EDGE_LO = 4,
  parameter int DMA_N   = 2
) (
  input  logic              clk,
  input  logic              hrst,
  input  logic              srst,
  input  logic [2:0]        addr,
  input  logic              we,
  input  logic [NLINES-1:0] wdata,
  input  logic [NLINES-1:0] pin_lvl,
  input  logic [NLINES-1:0] ev,
  output logic [NLINES-1:0] rdata,
  output logic [NLINES-1:0] dir,
  output logic [NLINES-1:0] dout,
  output logic [NLINES-1:0] edge_mode,
  output logic [NLINES-1:0] mask,
  output logic [DMA_N-1:0]  dma_en,
  output logic [DMA_N-1:0]  dma_lvl,
  output logic [NLINES-1:0] clr
);
  localparam int               CTL_W     = 2 * DMA_N;
  localparam logic [NLINES-1:0] EDGE_KEEP = {NLINES{1'b1}} << EDGE_LO;

  logic [CTL_W-1:0] dma_ctl;
  logic             any_rst;

  assign any_rst = hrst | srst;

  always_ff @(posedge clk) begin
    if (any_rst) begin
      dir     <= '0;
      dout    <= '0;
      mask    <= '0;
      dma_ctl <= '0;
    end else if (we) begin
      case (reg_addr_e'(addr))
        A_DIR:   dir     <= wdata;
        A_OUT:   dout    <= wdata;
        A_MASK:  mask    <= wdata;
        A_DMA:   dma_ctl <= wdata[CTL_W-1:0];
        default: ;
      endcase
    end
  end

  // trigger mode survives soft reset
  always_ff @(posedge clk) begin
    if (hrst)
      edge_mode <= '0;
    else if (!srst && we && (addr == A_EDGE))
      edge_mode <= wdata & EDGE_KEEP;
  end

  assign clr     = (we && !srst && (addr == A_EVT)) ? wdata : '0;
  assign dma_en  = dma_ctl[DMA_N-1:0];
  assign dma_lvl = dma_ctl[CTL_W-1:DMA_N];

  always_ff @(posedge clk) begin
    if (any_rst) begin
      rdata <= '0;
    end else begin
      case (reg_addr_e'(addr))
        A_DIR:   rdata <= dir;
        A_OUT:   rdata <= dout;
        A_PIN:   rdata <= pin_lvl;
        A_EDGE:  rdata <= edge_mode;
        A_EVT:   rdata <= ev;
        A_MASK:  rdata <= mask;
        A_DMA:   rdata <= {{(NLINES-CTL_W){1'b0}}, dma_ctl};
        default: rdata <= '0;
      endcase
    end
  end

  // R2
  edge_rsvd_chk: assert property (@(posedge clk) disable iff (any_rst)
    (addr == A_EDGE) |=> (rdata[EDGE_LO-1:0] == '0));

  // R8
  edge_keep_chk: assert property (@(posedge clk) disable iff (hrst)
    srst |=> $stable(edge_mode));
endmodule

// File: rtl/pio_edge_irq.sv
module pio_edge_irq #(
  parameter int NLINES  = 16,
  parameter int EDGE_LO = 4,
  parameter int DMA_N   = 2
) (
  input  logic              clk,
  input  logic              hrst,
  input  logic              srst,
  input  logic [2:0]        addr,
  input  logic              we,
  input  logic [NLINES-1:0] wdata,
  output logic [NLINES-1:0] rdata,
  input  logic [NLINES-1:0] pin_i,
  output logic [NLINES-1:0] pin_o,
  output logic [NLINES-1:0] pin_oe,
  output logic              irq,
  output logic [DMA_N-1:0]  dma_req
);
  localparam int DMA_BASE = NLINES - DMA_N;

  logic              any_rst;
  logic [NLINES-1:0] dir, dout, edge_mode, mask, clr, ev;
  logic [NLINES-1:0] lvl, fall, det;
  logic [DMA_N-1:0]  dma_en, dma_lvl;

  assign any_rst = hrst | srst;
  assign pin_oe  = dir;
  assign pin_o   = dout;

  pio_regs #(.NLINES(NLINES), .EDGE_LO(EDGE_LO), .DMA_N(DMA_N)) u_regs (
    .clk(clk), .hrst(hrst), .srst(srst), .addr(addr), .we(we), .wdata(wdata),
    .pin_lvl(lvl), .ev(ev), .rdata(rdata), .dir(dir), .dout(dout),
    .edge_mode(edge_mode), .mask(mask), .dma_en(dma_en), .dma_lvl(dma_lvl),
    .clr(clr)
  );

  pio_sync #(.NLINES(NLINES)) u_sync (
    .clk(clk), .rst(any_rst), .pin_i(pin_i), .edge_mode(edge_mode),
    .lvl(lvl), .fall(fall), .det(det)
  );

  pio_evt #(.NLINES(NLINES)) u_evt (
    .clk(clk), .rst(any_rst), .det(det), .dir(dir), .clr(clr), .mask(mask),
    .ev(ev), .irq(irq)
  );

  pio_dma #(.DMA_N(DMA_N)) u_dma (
    .clk(clk), .rst(any_rst), .en(dma_en), .lvl_mode(dma_lvl),
    .pin_lvl(lvl[DMA_BASE +: DMA_N]), .pin_fall(fall[DMA_BASE +: DMA_N]),
    .req(dma_req)
  );
endmodule

// File: tb/pio_edge_irq_tb.sv
`timescale 1ns/100ps
module pio_edge_irq_tb_top;
  logic        clk = 1'b0;
  logic        hrst = 1'b1, srst = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, pins = '0;
  logic [15:0] rdata, pin_o, pin_oe;
  logic        irq;
  logic [1:0]  dma_req;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  pio_edge_irq dut_i (
    .clk(clk), .hrst(hrst), .srst(srst), .addr(addr), .we(we), .wdata(wdata),
    .rdata(rdata), .pin_i(pins), .pin_o(pin_o), .pin_oe(pin_oe), .irq(irq),
    .dma_req(dma_req)
  );

  // monitor: compares queued reads right after the edge that loads rdata
  always @(posedge clk) begin
    logic [15:0] e;
    string t;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    we = 1'b0;
    addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic setpin(input int n, input logic v);
    @(negedge clk);
    pins[n] = v;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    hrst = 1'b0;
    settle();
    // R1 reset state
    rd(0, 16'h0000, "R1 dir");
    rd(4, 16'h0000, "R1 event");
    rd(5, 16'h0000, "R1 mask");
    rd(3, 16'h0000, "R1 mode");
    rd(6, 16'h0000, "R1 dma ctl");
    chk({15'd0, irq}, 16'h0, "R1 irq");
    chk({14'd0, dma_req}, 16'h0, "R1 dma_req");

    // R2 reserved mode bits
    wr(3, 16'hFFFF);
    rd(3, 16'hFFF0, "R2 mode readback");
    wr(3, 16'h8020);
    rd(3, 16'h8020, "R2 mode value");

    // R3 any-edge, with exact timing
    setpin(1, 1'b1);
    @(negedge clk);
    rd(4, 16'h0000, "R3 event not yet");
    rd(4, 16'h0002, "R3 rising event");
    wr(4, 16'h0002);
    rd(4, 16'h0000, "R3 cleared");
    setpin(1, 1'b0);
    settle();
    rd(4, 16'h0002, "R3 falling event");
    wr(4, 16'hFFFF);
    setpin(6, 1'b1);
    settle();
    rd(4, 16'h0040, "R3 rising on mode-capable line");
    wr(4, 16'hFFFF);

    // R4 falling only on line 5
    setpin(5, 1'b1);
    settle();
    rd(4, 16'h0000, "R4 rising ignored");
    setpin(5, 1'b0);
    settle();
    rd(4, 16'h0020, "R4 falling event");
    wr(4, 16'hFFFF);

    // R5 and R11: output line and register map
    wr(0, 16'h0080);
    wr(1, 16'h00A5);
    @(negedge clk);
    chk(pin_oe, 16'h0080, "R11 pin_oe");
    chk(pin_o, 16'h00A5, "R11 pin_o");
    setpin(7, 1'b1);
    settle();
    setpin(7, 1'b0);
    settle();
    rd(4, 16'h0000, "R5 output line quiet");
    rd(2, 16'h0040, "R11 pin level");
    rd(1, 16'h00A5, "R11 out readback");
    wr(0, 16'h0000);

    // R6 write-one-to-clear and same-cycle race
    setpin(1, 1'b1);
    settle();
    wr(4, 16'h0000);
    rd(4, 16'h0002, "R6 zero write keeps bit");
    setpin(1, 1'b0);
    @(negedge clk);
    wr(4, 16'h0002);
    rd(4, 16'h0002, "R6 new event wins");
    wr(4, 16'h0002);
    rd(4, 16'h0000, "R6 plain clear");

    // R7 interrupt
    wr(5, 16'h0002);
    setpin(1, 1'b1);
    repeat (3) @(negedge clk);
    chk({15'd0, irq}, 16'h0, "R7 irq not yet");
    @(negedge clk);
    chk({15'd0, irq}, 16'h1, "R7 irq raised");
    wr(4, 16'h0002);
    @(negedge clk);
    chk({15'd0, irq}, 16'h0, "R7 irq after clear");
    setpin(6, 1'b0);
    settle();
    chk({15'd0, irq}, 16'h0, "R7 masked event");
    wr(4, 16'hFFFF);

    // R9 edge DMA on line 15
    wr(6, 16'h0002);
    setpin(15, 1'b1);
    repeat (3) @(negedge clk);
    chk({14'd0, dma_req}, 16'h0, "R9 no pulse on rise");
    settle();
    setpin(15, 1'b0);
    repeat (2) @(negedge clk);
    chk({14'd0, dma_req}, 16'h0, "R9 pulse not yet");
    @(negedge clk);
    chk({14'd0, dma_req}, 16'h2, "R9 pulse");
    @(negedge clk);
    chk({14'd0, dma_req}, 16'h0, "R9 pulse one cycle");
    rd(4, 16'h8000, "R9 event still set");
    wr(4, 16'hFFFF);

    // R10 level DMA on line 14
    wr(6, 16'h0005);
    settle();
    chk({14'd0, dma_req}, 16'h1, "R10 low pin requests");
    setpin(14, 1'b1);
    repeat (2) @(negedge clk);
    chk({14'd0, dma_req}, 16'h1, "R10 still high");
    @(negedge clk);
    chk({14'd0, dma_req}, 16'h0, "R10 follows pin");
    setpin(14, 1'b0);
    settle();
    wr(6, 16'h0004);
    @(negedge clk);
    chk({14'd0, dma_req}, 16'h0, "R10 disabled");
    wr(4, 16'hFFFF);

    // R8 soft vs hard reset
    wr(0, 16'h0001);
    wr(5, 16'h0002);
    @(negedge clk); srst = 1'b1;
    @(negedge clk); srst = 1'b0;
    settle();
    rd(0, 16'h0000, "R8 dir cleared by soft");
    rd(5, 16'h0000, "R8 mask cleared by soft");
    rd(6, 16'h0000, "R8 dma cleared by soft");
    rd(3, 16'h8020, "R8 mode kept by soft");
    @(negedge clk); hrst = 1'b1;
    @(negedge clk); hrst = 1'b0;
    settle();
    rd(3, 16'h0000, "R8 mode cleared by hard");
    repeat (3) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule